// File: doc/BRIEF.md
# Triggered Iterative Waveform Update Sequencer

This block paces hardware-timed waveform output. Once it is armed by a start command, it waits for a trigger. After an accepted trigger it issues a train of single-cycle update strobes, each tagged with a pattern-buffer read address and an iteration index. A downstream DAC write path consumes these strobes. The pattern store, the DMA engine and the converter itself live outside the block.

One waveform is a run of `cfg_upd_per_iter` updates. With iterative generation enabled, the run repeats `cfg_iter_cnt` times, or without end when the infinite flag is set. An optional idle gap can separate iterations. An optional delay can hold off the first update after the trigger. In retrigger mode the block re-arms after each waveform until it has accepted the programmed number of triggers. Updates are paced either by an internal divider on the block clock or by rising edges of an external update line.

The pattern address runs continuously across iterations and wraps at the programmed pattern length. A short per-iteration count therefore walks a longer pattern piece by piece. All pins are plain control and status levels or pulses; no data stream crosses the boundary, so there is no valid/ready handshake. Configuration inputs must be held stable from start until the block is idle again.

Top module: `wavegen_seq`

## Requirements
- R1: After reset `upd` and `done` are 0, `busy` is 0 and `upd_addr` and `iter_idx` are 0. A trigger given while idle (not started) produces no update and leaves `busy` at 0.
- R2: After an accepted trigger, exactly U×I strobes are issued when `cfg_iter_en`=1 (U = `cfg_upd_per_iter`, I = `cfg_iter_cnt`, a value of 0 treated as 1), and exactly U when `cfg_iter_en`=0 (iteration count and gap ignored). After the last waveform `done` rises in the cycle of the final strobe, stays 1 with no further strobe, and `busy` is 0.
- R3: With the internal timer (`cfg_ext_sel`=0) and divider D (`cfg_tmr_div`, 0 treated as 1), with no delay or gap, update k (counting from 0) appears D·(k+1) clock edges after the edge that sampled the trigger.
- R4: With `cfg_dly_en`=1 the first update is pushed back by exactly `cfg_dly_clks` clocks. With `cfg_dly_en`=0 the value of `cfg_dly_clks` has no effect.
- R5: With `cfg_iter_en`=1, every update of iteration n is pushed back by n·`cfg_gap_clks` clocks. The gap is inserted only between iterations, and no strobe occurs during delay or gap.
- R6: Update k of a waveform carries `upd_addr` = k mod L (L = `cfg_pat_len`, 1..2^ADDR_W) and `iter_idx` = k div U. Address and index restart at 0 for each accepted trigger.
- R7: With `cfg_retrig_en`=1 the block accepts `cfg_trig_cnt` triggers (0 treated as 1) and returns to waiting between waveforms with `busy`=1 and `done`=0. Triggers that arrive during delay, run or gap, or after completion, are ignored.
- R8: With `cfg_iter_inf`=1 and `cfg_iter_en`=1, updates continue indefinitely and `done` never rises.
- R9: A `stop` pulse makes `upd` 0 and `busy` 0 from the next cycle, clears `done` and any pending trigger acceptance, and a later trigger produces nothing until a new `start`.
- R10: With `cfg_ext_sel`=1 exactly one update is issued per rising edge of `ext_upd` while running, however long the line stays high, and the internal timer produces none.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock (timebase) |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_upd_per_iter | input | CNT_W | Updates per iteration (U) |
| cfg_iter_cnt | input | CNT_W | Iteration count (I) |
| cfg_iter_en | input | 1 | Enable iterative generation |
| cfg_iter_inf | input | 1 | Iterate without end (needs cfg_iter_en) |
| cfg_dly_en | input | 1 | Enable post-trigger delay |
| cfg_dly_clks | input | CNT_W | Post-trigger delay in clocks |
| cfg_gap_clks | input | CNT_W | Idle clocks between iterations |
| cfg_retrig_en | input | 1 | Enable retrigger mode |
| cfg_trig_cnt | input | CNT_W | Number of triggers accepted in retrigger mode |
| cfg_ext_sel | input | 1 | 1: external update line, 0: internal timer |
| cfg_tmr_div | input | CNT_W | Internal timer period in clocks |
| cfg_pat_len | input | ADDR_W+1 | Pattern length in samples |
| start | input | 1 | Arm pulse (accepted when idle) |
| stop | input | 1 | Abort pulse, highest priority |
| trig | input | 1 | Trigger pulse |
| ext_upd | input | 1 | External update clock line |
| upd | output | 1 | Update strobe, one cycle per update |
| upd_addr | output | ADDR_W | Pattern address of the current update |
| iter_idx | output | CNT_W | Iteration index of the current update |
| busy | output | 1 | Armed or generating |
| done | output | 1 | Last waveform finished |

## Verification
A sweep over small per-iteration counts, iteration counts, divider values, iterative on or off, delay on or off and one or two triggers compares every strobe against an arithmetic timeline. This exposes off-by-one errors in the divider, delay and gap counters and in the iteration-end decision. A 16-sample pattern with two updates per iteration, together with short odd pattern lengths, separates correct address carry-over and wrap from per-iteration restart. Stray triggers fired mid-run or after completion, and a long external pulse, show that only acceptance edges and rising update edges count. An infinite run that is then stopped separates the abort path from normal completion.

// File: rtl/wg_pkg.sv
package wg_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_ARMED = 3'd1,
    ST_DELAY = 3'd2,
    ST_RUN   = 3'd3,
    ST_GAP   = 3'd4
  } wg_state_e;
endpackage

// File: rtl/wg_tick_src.sv
module wg_tick_src #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic             ext_sel_i,
  input  logic [CNT_W-1:0] div_i,
  input  logic             ext_i,
  output logic             tick_o
);
  logic [CNT_W-1:0] tcnt_q;
  logic [CNT_W-1:0] div_last;
  logic             ext_q;
  logic             int_hit;

  assign div_last = (div_i == '0) ? '0 : div_i - 1'b1;
  assign int_hit  = (tcnt_q >= div_last);
  assign tick_o   = run_i && (ext_sel_i ? (ext_i && !ext_q) : int_hit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tcnt_q <= '0;
      ext_q  <= 1'b0;
    end else begin
      ext_q <= ext_i;
      if (!run_i || ext_sel_i || int_hit) tcnt_q <= '0;
      else                                tcnt_q <= tcnt_q + 1'b1;
    end
  end

  // R3
  div_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && !ext_sel_i && div_i > 1 && tick_o) |=> !tick_o);
endmodule

// File: rtl/wg_addr_gen.sv
module wg_addr_gen #(
  parameter int ADDR_W = 9
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr_i,
  input  logic            step_i,
  input  logic [ADDR_W:0] len_i,
  output logic [ADDR_W-1:0] addr_o
);
  localparam int LEN_W = ADDR_W + 1;
  logic [ADDR_W-1:0] addr_q;
  logic [LEN_W-1:0]  last_w;

  assign last_w = (len_i == '0) ? '0 : len_i - 1'b1;
  assign addr_o = addr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      addr_q <= '0;
    else if (clr_i)  addr_q <= '0;
    else if (step_i) addr_q <= ({1'b0, addr_q} >= last_w) ? '0 : addr_q + 1'b1;
  end

  // R6
  addr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && len_i != '0) |-> ({1'b0, addr_q} < len_i));
endmodule

// File: rtl/wg_seq_fsm.sv
module wg_seq_fsm
  import wg_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             stop_i,
  input  logic             trig_i,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] uc_i,
  input  logic [CNT_W-1:0] ic_i,
  input  logic             iter_en_i,
  input  logic             inf_i,
  input  logic             dly_en_i,
  input  logic [CNT_W-1:0] dly_i,
  input  logic [CNT_W-1:0] gap_i,
  input  logic             retrig_en_i,
  input  logic [CNT_W-1:0] trig_cnt_i,
  output logic             run_o,
  output logic             step_o,
  output logic             addr_clr_o,
  output logic             upd_o,
  output logic [CNT_W-1:0] iter_o,
  output logic             busy_o,
  output logic             done_o
);
  wg_state_e        state_q;
  logic [CNT_W-1:0] ucnt_q, iter_q, wcnt_q, tacc_q, upd_iter_q;
  logic             upd_q, done_q;
  logic [CNT_W-1:0] uc_last, ic_last, tc_last;
  logic             last_upd, last_iter, more_trig;

  assign uc_last   = (uc_i == '0)       ? '0 : uc_i - 1'b1;
  assign ic_last   = (ic_i == '0)       ? '0 : ic_i - 1'b1;
  assign tc_last   = (trig_cnt_i == '0) ? '0 : trig_cnt_i - 1'b1;
  assign last_upd  = (ucnt_q >= uc_last);
  assign last_iter = !iter_en_i || (!inf_i && iter_q >= ic_last);
  assign more_trig = retrig_en_i && (tacc_q < tc_last);

  assign run_o      = (state_q == ST_RUN);
  assign step_o     = run_o && tick_i && !stop_i;
  assign addr_clr_o = ((state_q == ST_IDLE) && start_i) || ((state_q == ST_ARMED) && trig_i);
  assign upd_o      = upd_q;
  assign iter_o     = upd_iter_q;
  assign busy_o     = (state_q != ST_IDLE);
  assign done_o     = done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      ucnt_q     <= '0;
      iter_q     <= '0;
      wcnt_q     <= '0;
      tacc_q     <= '0;
      upd_iter_q <= '0;
      upd_q      <= 1'b0;
      done_q     <= 1'b0;
    end else begin
      upd_q <= 1'b0;
      if (stop_i) begin
        state_q <= ST_IDLE;
        done_q  <= 1'b0;
        tacc_q  <= '0;
        ucnt_q  <= '0;
        iter_q  <= '0;
      end else begin
        case (state_q)
          ST_IDLE: if (start_i) begin
            state_q <= ST_ARMED;
            done_q  <= 1'b0;
            tacc_q  <= '0;
            ucnt_q  <= '0;
            iter_q  <= '0;
          end
          ST_ARMED: if (trig_i) begin
            ucnt_q <= '0;
            iter_q <= '0;
            if (dly_en_i && dly_i != '0) begin
              state_q <= ST_DELAY;
              wcnt_q  <= dly_i - 1'b1;
            end else begin
              state_q <= ST_RUN;
            end
          end
          ST_DELAY, ST_GAP: begin
            if (wcnt_q == '0) state_q <= ST_RUN;
            else              wcnt_q  <= wcnt_q - 1'b1;
          end
          ST_RUN: if (tick_i) begin
            upd_q      <= 1'b1;
            upd_iter_q <= iter_q;
            if (!last_upd) begin
              ucnt_q <= ucnt_q + 1'b1;
            end else begin
              ucnt_q <= '0;
              if (!last_iter) begin
                iter_q <= iter_q + 1'b1;
                if (iter_en_i && gap_i != '0) begin
                  state_q <= ST_GAP;
                  wcnt_q  <= gap_i - 1'b1;
                end
              end else if (more_trig) begin
                tacc_q  <= tacc_q + 1'b1;
                state_q <= ST_ARMED;
              end else begin
                tacc_q  <= '0;
                state_q <= ST_IDLE;
                done_q  <= 1'b1;
              end
            end
          end
          default: state_q <= ST_IDLE;
        endcase
      end
    end
  end

  // R4 R5
  wait_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_DELAY || state_q == ST_GAP) |=> !upd_q);
  // R2
  done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && $past(done_q)) |-> !upd_q);
  // R9
  stop_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_i |=> (!upd_q && state_q == ST_IDLE && !done_q));
  // R8
  inf_no_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inf_i && iter_en_i && state_q != ST_IDLE && !stop_i) |=> !done_q);
endmodule

// File: rtl/wavegen_seq.sv
module wavegen_seq #(
  parameter int CNT_W  = 32,
  parameter int ADDR_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CNT_W-1:0]  cfg_upd_per_iter,
  input  logic [CNT_W-1:0]  cfg_iter_cnt,
  input  logic              cfg_iter_en,
  input  logic              cfg_iter_inf,
  input  logic              cfg_dly_en,
  input  logic [CNT_W-1:0]  cfg_dly_clks,
  input  logic [CNT_W-1:0]  cfg_gap_clks,
  input  logic              cfg_retrig_en,
  input  logic [CNT_W-1:0]  cfg_trig_cnt,
  input  logic              cfg_ext_sel,
  input  logic [CNT_W-1:0]  cfg_tmr_div,
  input  logic [ADDR_W:0]   cfg_pat_len,
  input  logic              start,
  input  logic              stop,
  input  logic              trig,
  input  logic              ext_upd,
  output logic              upd,
  output logic [ADDR_W-1:0] upd_addr,
  output logic [CNT_W-1:0]  iter_idx,
  output logic              busy,
  output logic              done
);
  logic              run_w, tick_w, step_w, clr_w;
  logic [ADDR_W-1:0] addr_w;
  logic [ADDR_W-1:0] upd_addr_q;

  wg_tick_src #(.CNT_W(CNT_W)) u_tick (
    .clk       (clk),
    .rst_n     (rst_n),
    .run_i     (run_w),
    .ext_sel_i (cfg_ext_sel),
    .div_i     (cfg_tmr_div),
    .ext_i     (ext_upd),
    .tick_o    (tick_w)
  );

  wg_seq_fsm #(.CNT_W(CNT_W)) u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start),
    .stop_i      (stop),
    .trig_i      (trig),
    .tick_i      (tick_w),
    .uc_i        (cfg_upd_per_iter),
    .ic_i        (cfg_iter_cnt),
    .iter_en_i   (cfg_iter_en),
    .inf_i       (cfg_iter_inf),
    .dly_en_i    (cfg_dly_en),
    .dly_i       (cfg_dly_clks),
    .gap_i       (cfg_gap_clks),
    .retrig_en_i (cfg_retrig_en),
    .trig_cnt_i  (cfg_trig_cnt),
    .run_o       (run_w),
    .step_o      (step_w),
    .addr_clr_o  (clr_w),
    .upd_o       (upd),
    .iter_o      (iter_idx),
    .busy_o      (busy),
    .done_o      (done)
  );

  wg_addr_gen #(.ADDR_W(ADDR_W)) u_addr (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr_i  (clr_w),
    .step_i (step_w),
    .len_i  (cfg_pat_len),
    .addr_o (addr_w)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      upd_addr_q <= '0;
    else if (step_w) upd_addr_q <= addr_w;
  end
  assign upd_addr = upd_addr_q;
endmodule

// File: tb/wavegen_seq_bench.sv
module wavegen_seq_bench;
  localparam int CW = 16;
  localparam int AW = 5;

  logic clk = 0, rst_n = 0;
  logic [CW-1:0] cfg_uc, cfg_ic, cfg_dly, cfg_gap, cfg_tc, cfg_div;
  logic cfg_iter_en, cfg_inf, cfg_dly_en, cfg_retrig, cfg_ext;
  logic [AW:0] cfg_len;
  logic start = 0, stop = 0, trig = 0, ext_upd = 0;
  logic upd, busy, done;
  logic [AW-1:0] upd_addr;
  logic [CW-1:0] iter_idx;

  wavegen_seq #(.CNT_W(CW), .ADDR_W(AW)) u_wavegen_seq (
    .clk(clk), .rst_n(rst_n),
    .cfg_upd_per_iter(cfg_uc), .cfg_iter_cnt(cfg_ic), .cfg_iter_en(cfg_iter_en),
    .cfg_iter_inf(cfg_inf), .cfg_dly_en(cfg_dly_en), .cfg_dly_clks(cfg_dly),
    .cfg_gap_clks(cfg_gap), .cfg_retrig_en(cfg_retrig), .cfg_trig_cnt(cfg_tc),
    .cfg_ext_sel(cfg_ext), .cfg_tmr_div(cfg_div), .cfg_pat_len(cfg_len),
    .start(start), .stop(stop), .trig(trig), .ext_upd(ext_upd),
    .upd(upd), .upd_addr(upd_addr), .iter_idx(iter_idx), .busy(busy), .done(done)
  );

  always #5 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_chk = 0, n_bad = 0;
  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  // expected-timeline monitor
  bit mon_on = 0, mon_timed = 1;
  int mon_base, mon_k, mon_total, mon_uc, mon_len, mon_div, mon_dly, mon_gap;
  always @(negedge clk) begin
    if (rst_n && upd) begin
      if (!mon_on || mon_k >= mon_total) begin
        chk(0, "R2/R7/R9 unexpected update strobe", 1, 0);
      end else begin
        int it, et;
        it = mon_k / mon_uc;
        chk(upd_addr == AW'(mon_k % mon_len), "R6 address", int'(upd_addr), mon_k % mon_len);
        chk(iter_idx == CW'(it), "R6 iteration index", int'(iter_idx), it);
        if (mon_timed) begin
          et = mon_base + mon_dly + mon_div * (mon_k + 1) + mon_gap * it;
          chk(cyc == et, "R3/R4/R5 update time", cyc, et);
        end
        mon_k++;
      end
    end
  end

  task automatic pulse(ref logic s);
    @(negedge clk) s = 1;
    @(negedge clk) s = 0;
  endtask

  // fire an accepted trigger and arm the monitor timeline
  task automatic fire_trig();
    mon_k = 0;
    mon_on = 1;
    @(negedge clk) trig = 1;
    @(negedge clk) trig = 0;
    mon_base = cyc;
  endtask

  task automatic run_case(input int uc, input int ic, input int ien, input int den,
                          input int dly, input int gap, input int div, input int len,
                          input int ntrig);
    int iters, endt;
    @(negedge clk);
    cfg_uc = CW'(uc); cfg_ic = CW'(ic); cfg_iter_en = ien[0]; cfg_inf = 0;
    cfg_dly_en = den[0]; cfg_dly = CW'(dly); cfg_gap = CW'(gap); cfg_div = CW'(div);
    cfg_len = (AW+1)'(len); cfg_retrig = (ntrig > 1); cfg_tc = CW'(ntrig); cfg_ext = 0;
    iters = ien ? ic : 1;
    mon_uc = uc; mon_len = len; mon_div = div; mon_timed = 1;
    mon_dly = den ? dly : 0;
    mon_gap = ien ? gap : 0;
    mon_total = uc * iters;
    endt = mon_dly + div * mon_total + mon_gap * (iters - 1);
    pulse(start);
    repeat (2) @(negedge clk);
    for (int t = 0; t < ntrig; t++) begin
      fire_trig();
      if (endt > 4) begin
        @(negedge clk);
        trig = 1;  // R7: stray trigger while generating, must be ignored
        @(negedge clk) trig = 0;
      end
      while (mon_k < mon_total) @(negedge clk);
      repeat (div + 3) @(negedge clk);
      chk(mon_k == mon_total, "R2 strobe count", mon_k, mon_total);
      if (t == ntrig - 1) begin
        chk(done == 1'b1, "R2 done after last waveform", int'(done), 1);
        chk(busy == 1'b0, "R2 idle after last waveform", int'(busy), 0);
      end else begin
        chk(done == 1'b0, "R7 done low between retriggers", int'(done), 0);
        chk(busy == 1'b1, "R7 re-armed between retriggers", int'(busy), 1);
      end
    end
    // R7: trigger after completion is ignored
    pulse(trig);
    repeat (div + 3) @(negedge clk);
    chk(done == 1'b1, "R7 trigger after completion ignored", int'(done), 1);
    mon_on = 0;
  endtask

  initial begin
    cfg_uc = 1; cfg_ic = 1; cfg_iter_en = 0; cfg_inf = 0; cfg_dly_en = 0; cfg_dly = 0;
    cfg_gap = 0; cfg_retrig = 0; cfg_tc = 1; cfg_ext = 0; cfg_div = 1; cfg_len = 4;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1
    chk(upd == 0, "R1 reset upd", int'(upd), 0);
    chk(done == 0, "R1 reset done", int'(done), 0);
    chk(busy == 0, "R1 reset busy", int'(busy), 0);
    chk(upd_addr == 0, "R1 reset address", int'(upd_addr), 0);
    chk(iter_idx == 0, "R1 reset iteration index", int'(iter_idx), 0);
    pulse(trig);
    repeat (5) @(negedge clk);
    chk(busy == 0, "R1 trigger while idle ignored", int'(busy), 0);

    // sweep: R2 R3 R4 R5 R6 R7
    for (int uc = 1; uc <= 3; uc++)
      for (int ic = 1; ic <= 3; ic++)
        for (int ien = 0; ien <= 1; ien++)
          for (int div = 1; div <= 2; div++)
            run_case(uc, ic, ien, (uc + ic + ien) % 2, 1 + ((uc + ic) % 3) * 2,
                     (uc + div) % 3, div, 2 + (uc * ic + div) % 4,
                     1 + ((uc + ic + div) % 2));

    // R6: piecewise walk of a 16-sample pattern, 2 updates per iteration
    run_case(2, 8, 1, 0, 0, 0, 1, 16, 1);
    // R6: odd length wrap across iterations with gap and delay
    run_case(2, 4, 1, 1, 3, 2, 2, 5, 2);

    // R8 R9: infinite iteration, then stop
    @(negedge clk);
    cfg_uc = 3; cfg_ic = 1; cfg_iter_en = 1; cfg_inf = 1; cfg_dly_en = 0; cfg_gap = 1;
    cfg_div = 2; cfg_len = 4; cfg_retrig = 0; cfg_tc = 1; cfg_ext = 0;
    mon_uc = 3; mon_len = 4; mon_div = 2; mon_dly = 0; mon_gap = 1; mon_total = 100000;
    mon_timed = 1;
    pulse(start);
    fire_trig();
    while (mon_k < 20) @(negedge clk);
    chk(done == 0, "R8 infinite run never done", int'(done), 0);
    chk(busy == 1, "R8 infinite run still busy", int'(busy), 1);
    @(negedge clk) stop = 1;
    @(negedge clk) stop = 0;
    chk(upd == 0, "R9 strobe low after stop", int'(upd), 0);
    chk(busy == 0, "R9 idle after stop", int'(busy), 0);
    chk(done == 0, "R9 done clear after stop", int'(done), 0);
    mon_on = 0;
    pulse(trig);
    repeat (10) @(negedge clk);
    chk(busy == 0, "R9 trigger after stop needs new start", int'(busy), 0);

    // R10: external update clock
    @(negedge clk);
    cfg_uc = 2; cfg_ic = 2; cfg_iter_en = 1; cfg_inf = 0; cfg_gap = 0; cfg_div = 1;
    cfg_len = 3; cfg_ext = 1;
    mon_uc = 2; mon_len = 3; mon_total = 4; mon_timed = 0;
    pulse(start);
    fire_trig();
    repeat (10) @(negedge clk);
    chk(mon_k == 0, "R10 internal timer idle in external mode", mon_k, 0);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk) ext_upd = 1;
      repeat (3) @(negedge clk);
      ext_upd = 0;
      repeat (2) @(negedge clk);
      chk(mon_k == i + 1, "R10 one update per external edge", mon_k, i + 1);
    end
    chk(done == 1, "R10/R2 done after external run", int'(done), 1);
    mon_on = 0;

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 10);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule